// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. The input clock is divided by a programmable ratio N = P·B + A. A digitally modelled dual-modulus prescaler counts input clock cycles. It divides by P+1 while the swallow count A is still running, and by P for the remaining prescaler periods until the main count B is used up. One narrow pulse comes out per frame of N input cycles. That pulse feeds the phase detector.

The lower modulus P is picked from a pair by the `div_sel` input. The pair is fixed per instance by the parameter `P_LO_LOG2`: 3 gives 8/9 and 16/17, 4 gives 16/17 and 32/33, 5 gives 32/33 and 64/65, 6 gives 64/65 and 128/129.

A sequencer with four named states controls the counts:
- IDLE is the state after reset. It always moves on at the next edge, to SWALLOW, MAIN or HALT.
- SWALLOW runs the prescaler at P+1. It moves to MAIN when the swallow count reaches zero.
- MAIN runs the prescaler at P.
- HALT is entered on an illegal setting. It moves to SWALLOW (when A ≠ 0) or to MAIN (when A = 0) once the inputs become legal.

At every frame end, in either SWALLOW or MAIN, the sequencer reloads from the inputs. It goes to SWALLOW if A ≠ 0, to MAIN if A = 0, and to HALT if the new setting is illegal. The inputs are read only on edges where a load happens, so an output period is never disturbed.

Top module: `swallow_divider`

## Requirements
- R1: While the setting is legal, consecutive `div_pulse` assertions are exactly P·B + A input cycles apart. B and A are the `main_b` and `swallow_a` values present at the edge that started that frame.
- R2: `div_sel` = 0 selects P = 2^P_LO_LOG2. `div_sel` = 1 selects P = 2^(P_LO_LOG2+1).
- R3: `div_pulse` is high for exactly one input cycle per frame.
- R4: The corner settings A = 0 and A = B both give a frame of P·B + A cycles.
- R5: Changes to `div_sel`, `swallow_a` or `main_b` that occur away from a frame boundary have no effect on the running frame. This includes an illegal value that is removed again before the boundary. `cfg_err` stays low during such a change.
- R6: A setting is illegal when B < 3 or B < A (A after masking, see R8). When an illegal setting is loaded, `cfg_err` goes high one cycle after the loading edge. It stays high, and `div_pulse` stays low, for as long as the inputs remain illegal. The frame that ended on that load produces no pulse.
- R7: In HALT, a legal setting is loaded at the next edge. `cfg_err` is low from the following cycle, and the first `div_pulse` appears N cycles after that.
- R8: With the parameter NARROW_A = 1, only bits 3:0 of `swallow_a` are used. Bits 6:4 have no effect on the ratio or on legality.
- R9: During reset `div_pulse` and `cfg_err` are low. After reset is released, the first edge loads the inputs, and the first pulse appears N+1 cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 1 | Prescaler modulus pair select (0: P low, 1: P doubled) |
| swallow_a | input | A_W (7) | Swallow count A |
| main_b | input | B_W (11) | Main count B |
| div_pulse | output | 1 | One-cycle pulse per frame of N input cycles |
| cfg_err | output | 1 | Illegal setting loaded; output held quiet |

## Verification
A wrong swallow or main count, or a prescaler modulus chosen in the wrong state, shows up as a pulse spacing that differs from P·B + A. This is visible at the very next pulse after the faulty frame, so at most one frame late. A sequencer that latches inputs in mid-frame shows up as a frame whose length matches a transient setting rather than the one present at its start. A missed or sticky HALT shows as `cfg_err` failing to follow the legality of the loaded setting one cycle after the loading edge, or as a pulse while the flag is high.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_HALT    = 2'd3
    } swd_state_e;
endpackage

// File: rtl/swd_check.sv
module swd_check #(
    parameter int A_W      = 7,
    parameter int B_W      = 11,
    parameter bit NARROW_A = 1'b0
) (
    input  logic [A_W-1:0] a_raw,
    input  logic [B_W-1:0] b_raw,
    output logic [A_W-1:0] a_eff,
    output logic           legal
);
    localparam int NARROW_W = 4;
    localparam logic [B_W-1:0] B_MIN = B_W'(3);

    generate
        if (NARROW_A) begin : g_narrow
            logic unused_hi_bits;
            assign unused_hi_bits = ^a_raw[A_W-1:NARROW_W];
            assign a_eff = {{(A_W-NARROW_W){1'b0}}, a_raw[NARROW_W-1:0]};
        end else begin : g_full
            assign a_eff = a_raw;
        end
    endgenerate

    always_comb begin
        legal = (b_raw >= B_MIN) && (b_raw >= B_W'(a_eff));
    end
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int PC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            hi_mod,
    input  logic [PC_W-1:0] p_lo,
    output logic            tick
);
    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] last;

    always_comb begin
        last = hi_mod ? p_lo : (p_lo - PC_W'(1));
        tick = (pcnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PC_W'(1);
        end
    end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
    import swd_pkg::*;
#(
    parameter int A_W = 7,
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           legal,
    input  logic [A_W-1:0] a_eff,
    input  logic [B_W-1:0] b_in,
    input  logic           sel_in,
    output swd_state_e     state,
    output logic           sel_q,
    output logic           running,
    output logic           load_evt,
    output logic           frame_end
);
    swd_state_e      state_nx;
    swd_state_e      entry_st;
    logic [A_W-1:0]  acnt;
    logic [B_W-1:0]  bcnt;

    always_comb begin
        running   = (state == ST_SWALLOW) || (state == ST_MAIN);
        frame_end = running && tick && (bcnt == B_W'(1));
        load_evt  = (state == ST_IDLE) || (state == ST_HALT) || frame_end;
        if (!legal)
            entry_st = ST_HALT;
        else if (a_eff != '0)
            entry_st = ST_SWALLOW;
        else
            entry_st = ST_MAIN;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = entry_st;
            ST_HALT:    state_nx = entry_st;
            ST_SWALLOW: begin
                if (frame_end)
                    state_nx = entry_st;
                else if (tick && (acnt == A_W'(1)))
                    state_nx = ST_MAIN;
            end
            ST_MAIN: begin
                if (frame_end)
                    state_nx = entry_st;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt  <= '0;
            bcnt  <= '0;
            sel_q <= 1'b0;
        end else if (load_evt) begin
            acnt  <= a_eff;
            bcnt  <= b_in;
            sel_q <= sel_in;
        end else if (running && tick) begin
            bcnt <= bcnt - B_W'(1);
            if (state == ST_SWALLOW)
                acnt <= acnt - A_W'(1);
        end
    end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swd_pkg::*;
#(
    parameter int A_W       = 7,
    parameter int B_W       = 11,
    parameter int P_LO_LOG2 = 3,
    parameter bit NARROW_A  = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           div_sel,
    input  logic [A_W-1:0] swallow_a,
    input  logic [B_W-1:0] main_b,
    output logic           div_pulse,
    output logic           cfg_err
);
    localparam int PC_W = P_LO_LOG2 + 2;
    localparam logic [PC_W-1:0] P_SMALL = PC_W'(1) << P_LO_LOG2;
    localparam logic [PC_W-1:0] P_LARGE = PC_W'(1) << (P_LO_LOG2 + 1);

    logic           legal;
    logic [A_W-1:0] a_eff;
    logic           tick;
    logic           sel_q;
    logic           running;
    logic           load_evt;
    logic           frame_end;
    logic [PC_W-1:0] p_lo;
    swd_state_e     state;

    swd_check #(.A_W(A_W), .B_W(B_W), .NARROW_A(NARROW_A)) u_check (
        .a_raw (swallow_a),
        .b_raw (main_b),
        .a_eff (a_eff),
        .legal (legal)
    );

    assign p_lo = sel_q ? P_LARGE : P_SMALL;

    swd_prescaler #(.PC_W(PC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!running || load_evt),
        .hi_mod (state == ST_SWALLOW),
        .p_lo   (p_lo),
        .tick   (tick)
    );

    swd_seq #(.A_W(A_W), .B_W(B_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .legal     (legal),
        .a_eff     (a_eff),
        .b_in      (main_b),
        .sel_in    (div_sel),
        .state     (state),
        .sel_q     (sel_q),
        .running   (running),
        .load_evt  (load_evt),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= frame_end && legal;
        end
    end

    assign cfg_err = (state == ST_HALT);
endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
    parameter int A_W       = 7,
    parameter int B_W       = 11,
    parameter int P_LO_LOG2 = 3,
    parameter bit NARROW_A  = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           div_sel,
    input logic [A_W-1:0] swallow_a,
    input logic [B_W-1:0] main_b,
    input logic           div_pulse,
    input logic           cfg_err
);
    localparam int CNT_W = P_LO_LOG2 + 2 + B_W + 1;

    logic [A_W-1:0]   a_use;
    logic             legal_in;
    logic             sel_p;
    logic [A_W-1:0]   a_p;
    logic [B_W-1:0]   b_p;
    logic [CNT_W-1:0] exp_n;
    logic [CNT_W-1:0] gap;
    logic             armed;

    always_comb begin
        a_use = NARROW_A ? (swallow_a & A_W'(15)) : swallow_a;
        legal_in = (main_b >= B_W'(3)) && ({{(CNT_W-B_W){1'b0}}, main_b} >= CNT_W'(a_use));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_p <= 1'b0;
            a_p   <= '0;
            b_p   <= '0;
            exp_n <= '0;
            gap   <= '0;
            armed <= 1'b0;
        end else begin
            sel_p <= div_sel;
            a_p   <= NARROW_A ? (swallow_a & A_W'(15)) : swallow_a;
            b_p   <= main_b;
            if (cfg_err) begin
                armed <= 1'b0;
                gap   <= '0;
            end else if (div_pulse) begin
                exp_n <= (CNT_W'(b_p) << (sel_p ? P_LO_LOG2 + 1 : P_LO_LOG2)) + CNT_W'(a_p);
                gap   <= CNT_W'(1);
                armed <= 1'b1;
            end else begin
                gap <= gap + CNT_W'(1);
            end
        end
    end

    a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !div_pulse);

    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    a_r6_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !$past(legal_in));

    a_r7_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_err) |-> $past(legal_in));

    a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && div_pulse && !cfg_err) |-> (gap == exp_n));

    a_r1_no_late_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !div_pulse && !cfg_err) |-> (gap < exp_n));
endmodule

bind swallow_divider swd_chk #(
    .A_W(A_W), .B_W(B_W), .P_LO_LOG2(P_LO_LOG2), .NARROW_A(NARROW_A)
) u_swd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_sel   (div_sel),
    .swallow_a (swallow_a),
    .main_b    (main_b),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
    localparam int CLK_PERIOD = 10;
    localparam int LOG2P      = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_sel = 1'b0;
    logic [6:0]  swallow_a = 7'd3;
    logic [10:0] main_b = 11'd5;
    logic        div_pulse;
    logic        cfg_err;

    logic        n_sel = 1'b0;
    logic [6:0]  n_a = 7'b1110011;
    logic [10:0] n_b = 11'd10;
    logic        n_pulse;
    logic        n_err;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int exp_q[$];
    bit have_exp = 1'b0;
    int cur_exp = 0;
    int gap = 0;
    bit prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swallow_divider #(.P_LO_LOG2(LOG2P)) dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .swallow_a(swallow_a),
        .main_b(main_b), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    swallow_divider #(.P_LO_LOG2(LOG2P), .NARROW_A(1'b1)) dut_nar (
        .clk(clk), .rst_n(rst_n), .div_sel(n_sel), .swallow_a(n_a),
        .main_b(n_b), .div_pulse(n_pulse), .cfg_err(n_err)
    );

    function automatic int ratio(input bit s, input int a, input int b);
        int p;
        p = s ? (1 << (LOG2P + 1)) : (1 << LOG2P);
        return p * b + a;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // monitor: scoreboard of frame lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (div_pulse && prev_pulse)
                check(1'b0, "R3 pulse width", 2, 1);
            prev_pulse = div_pulse;
            if (cfg_err) begin
                have_exp = 1'b0;
                gap = 0;
            end else if (div_pulse) begin
                if (have_exp)
                    check(gap + 1 == cur_exp, "R1 frame length", gap + 1, cur_exp);
                if (exp_q.size() > 0) begin
                    cur_exp = exp_q.pop_front();
                    have_exp = 1'b1;
                end else begin
                    have_exp = 1'b0;
                end
                gap = 0;
            end else begin
                gap++;
            end
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
        #1;
    endtask

    task automatic apply(input bit s, input int a, input int b);
        wait_pulse();
        div_sel = s;
        swallow_a = 7'(a);
        main_b = 11'(b);
        exp_q.push_back(ratio(s, a, b));
    endtask

    // R5: transient change, then final setting, all within one frame
    task automatic glitch(input int xa, input int xb, input bit s, input int a, input int b);
        wait_pulse();
        div_sel = ~div_sel;
        swallow_a = 7'(xa);
        main_b = 11'(xb);
        repeat (5) @(negedge clk);
        check(cfg_err == 1'b0, "R5 err during mid-frame change", int'(cfg_err), 0);
        #1;
        div_sel = s;
        swallow_a = 7'(a);
        main_b = 11'(b);
        exp_q.push_back(ratio(s, a, b));
    endtask

    // R6 then R7
    task automatic fault_and_recover(input int bad_a, input int bad_b,
                                     input bit s, input int a, input int b);
        int n;
        bit quiet;
        wait_pulse();
        exp_q.delete();
        swallow_a = 7'(bad_a);
        main_b = 11'(bad_b);
        n = 0;
        do begin @(negedge clk); n++; end while (!cfg_err && n < 5000);
        check(cfg_err == 1'b1, "R6 err rises on illegal load", int'(cfg_err), 1);
        quiet = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (!cfg_err || div_pulse) quiet = 1'b0;
        end
        check(quiet, "R6 err held and pulse low", int'(quiet), 1);
        #1;
        div_sel = s;
        swallow_a = 7'(a);
        main_b = 11'(b);
        exp_q.push_back(ratio(s, a, b));
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 err clears one cycle after legal load", int'(cfg_err), 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!div_pulse && n < 70000);
        check(n == ratio(s, a, b), "R7 first pulse after recovery", n, ratio(s, a, b));
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0 && cfg_err == 1'b0, "R9 reset outputs",
              int'({div_pulse, cfg_err}), 0);
        exp_q.push_back(ratio(0, 3, 5));
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!div_pulse && n < 5000);
        check(n == ratio(0, 3, 5) + 1, "R9 first pulse after release", n, ratio(0, 3, 5) + 1);
        #1;

        // R2: modulus select both ways; R1 basic
        apply(1'b1, 3, 5);
        apply(1'b0, 7, 9);
        // R4: A = 0 at minimum B, and A = B
        apply(1'b0, 0, 3);
        apply(1'b1, 20, 20);
        apply(1'b1, 3, 3);
        // R1: random legal settings
        for (int i = 0; i < 12; i++) begin
            int rb, ra;
            rb = 3 + int'($urandom_range(0, 60));
            ra = int'($urandom_range(0, rb > 127 ? 127 : rb));
            apply(1'($urandom_range(0, 1)), ra, rb);
        end
        // R5: mid-frame illegal and legal transients
        glitch(9, 1, 1'b0, 11, 12);
        glitch(60, 100, 1'b1, 2, 4);
        // R1/R4: extreme setting
        apply(1'b0, 127, 2047);
        apply(1'b0, 5, 6);
        // R6/R7: B below 3, then B below A
        fault_and_recover(0, 2, 1'b0, 4, 8);
        apply(1'b1, 6, 7);
        fault_and_recover(30, 10, 1'b1, 10, 10);
        apply(1'b0, 1, 4);
        wait_pulse();
        wait_pulse();
        wait_pulse();
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

    // R8: narrow instance ignores bits 6:4 of A (0x73 -> 3), N = 8*10+3
    initial begin
        int n;
        @(posedge rst_n);
        do @(negedge clk); while (!n_pulse);
        n = 0;
        do begin @(negedge clk); n++; end while (!n_pulse && n < 5000);
        check(n == 83, "R8 narrow A ratio", n, 83);
        check(n_err == 1'b0, "R8 narrow A legality", int'(n_err), 0);
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule